// File: doc/BRIEF.md
# Flash Controller Serial Register Target

This block is the two-wire serial target of an LED flash controller. It watches a serial clock and a serial data line that are sampled by the system clock. It cleans both lines, detects START, repeated START and STOP, and answers only to its fixed 7-bit device address. A write transaction carries a subaddress byte and one data byte, which land in one of four 8-bit registers. A read transaction sets the subaddress, issues a repeated START with the read bit, and gets back one byte from the addressed register.

The register contents are not exposed as bytes. The block drives decoded fields: the high-power LED current code, the indicator LED current code, the flash timer mode, the flash timer setting and the software strobe bit. A 4-bit fault status input sets sticky bits in a read-only fault register. Writing 0x00 to the output-select register clears those bits and emits a one-cycle fault-clear pulse for the interrupt logic. Pulling the enable low, or raising the undervoltage flag, returns every register to 0x00. The data line is open-drain, so the block only drives an output-enable that pulls the line low.

Top module: `flash_i2c_regfile`

## Requirements
- R1: The target acknowledges only the address byte 0xC0 (write) or 0xC1 (read), which is device address 0x60. Any other address gets no ACK, and the rest of that transaction changes no register.
- R2: A write (START, 0xC0, subaddress, data, STOP) to subaddress 0 stores the data byte. The high-power current code is bits 7..3 and the indicator current code is bits 2..0.
- R3: Subaddress 1 keeps bits 4..0: bit 4 is the timed-flash mode and bits 3..0 are the timer setting. It reads back with bits 7..5 as zero. Subaddress 2 keeps bit 0 only, as the software strobe.
- R4: At reset, and in the cycle after chip_en is low or uv_flag is high, all four registers and every decoded output are zero.
- R5: A read (START, 0xC0, subaddress, repeated START, 0xC1, one byte, master NACK, STOP) returns the addressed register MSB first. In subaddress 3, bit 0 is overvoltage, bit 1 is timeout, bit 2 is overtemperature and bit 3 is short-circuit, and these bits come from fault_in[0..3].
- R6: Writing 0x00 to subaddress 0 clears the fault register and raises fault_clr for exactly one cycle. Writing any non-zero value to subaddress 0 leaves the fault register unchanged.
- R7: A fault_in bit that is high for one cycle sets its fault bit, and the bit stays set until it is cleared. fault_any is high whenever any fault bit is set.
- R8: Subaddresses above 3 are acknowledged, writes to them are dropped, and reads from them return 0x00. Writes to subaddress 3 are dropped.
- R9: Each write transaction stores only its first data byte. A further data byte before STOP gets no ACK and is not stored.
- R10: An SCL pulse shorter than FILT_LEN system clock cycles (default 3, i.e. 60 ns at 50 MHz) is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Enable; low clears all registers |
| uv_flag | input | 1 | Supply undervoltage; high clears all registers |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line, asynchronous |
| sda_oe | output | 1 | High pulls the data line low |
| fault_in | input | 4 | Fault detector flags (overvoltage, timeout, overtemperature, short-circuit) |
| hp_level | output | 5 | High-power LED current code |
| ind_level | output | 3 | Indicator LED current code |
| timed_mode | output | 1 | Timed-flash mode select |
| flash_time | output | 4 | Flash timer setting |
| soft_strobe | output | 1 | Software strobe bit |
| fault_any | output | 1 | Any fault bit set |
| fault_clr | output | 1 | One-cycle pulse when faults are cleared by a write |

## Verification
Two situations are hard to reach from the ports. The first is an SCL glitch in the middle of a byte. The bench drives a two-cycle high pulse on SCL while the line is low, during a data byte, and then reads the register back to show that no extra bit was shifted in. The second is an extra data byte after the one that is stored. The bench hand-builds a transaction with that byte, checks that its ACK slot is left released, and reads back the value that the first byte stored. The fault-clear path is reached by pulsing fault_in between transactions, then writing non-zero and zero values to the output-select register and counting the fault_clr pulses.

// File: rtl/flash_i2c_pkg.sv
package flash_i2c_pkg;
  // Field widths of the decoded register contents
  localparam int unsigned HP_W   = 5;
  localparam int unsigned IND_W  = 3;
  localparam int unsigned TSEL_W = 4;
  localparam int unsigned FLT_W  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CFG_W  = TSEL_W + 1;

  // Subaddress map
  localparam logic [BYTE_W-1:0] SUB_OUT = 8'd0;
  localparam logic [BYTE_W-1:0] SUB_CFG = 8'd1;
  localparam logic [BYTE_W-1:0] SUB_STB = 8'd2;
  localparam logic [BYTE_W-1:0] SUB_FLT = 8'd3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_SUB,
    BY_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic s1_q, s2_q;
  logic out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // two-flop synchroniser, idle bus level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  // accept a new level only after FILT_LEN consecutive differing samples
  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (s2_q != out_q) begin
      if (cnt_q == CNT_LAST) begin
        out_d = s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  // data edge while the clock stays high
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import flash_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_sub,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_sub,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [3:0] FULL   = 4'(BYTE_W);
  localparam logic [3:0] LASTTX = 4'(BYTE_W - 1);

  phase_t            ph_q, ph_d;
  byte_kind_t        kind_q, kind_d;
  logic [3:0]        bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic              byte_done;

  assign byte_done = (ph_q == PH_RX) && (bcnt_q == FULL) && scl_fall;

  always_comb begin
    ph_d   = ph_q;
    kind_d = kind_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    oe_d   = oe_q;
    if (start_det) begin
      ph_d   = PH_RX;
      kind_d = BY_ADDR;
      bcnt_d = '0;
      oe_d   = 1'b0;
    end else if (stop_det) begin
      ph_d = PH_IDLE;
      oe_d = 1'b0;
    end else begin
      case (ph_q)
        PH_RX: begin
          if (scl_rise && (bcnt_q < FULL)) begin
            sh_d   = {sh_q[BYTE_W-2:0], sda_f};
            bcnt_d = bcnt_q + 4'd1;
          end else if (byte_done) begin
            case (kind_q)
              BY_ADDR: begin
                if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                  rw_d = sh_q[0];
                  oe_d = 1'b1;
                  ph_d = PH_ACK;
                end else begin
                  ph_d = PH_IDLE;
                end
              end
              BY_SUB: begin
                ptr_d = sh_q;
                oe_d  = 1'b1;
                ph_d  = PH_ACK;
              end
              default: begin
                oe_d = 1'b1;
                ph_d = PH_ACK;
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            oe_d   = 1'b0;
            bcnt_d = '0;
            if (kind_q == BY_ADDR && rw_q) begin
              ph_d = PH_TX;
              sh_d = rd_data;
              oe_d = ~rd_data[BYTE_W-1];
            end else if (kind_q == BY_ADDR) begin
              kind_d = BY_SUB;
              ph_d   = PH_RX;
            end else if (kind_q == BY_SUB) begin
              kind_d = BY_DATA;
              ph_d   = PH_RX;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bcnt_q == LASTTX) begin
              ph_d = PH_MACK;
              oe_d = 1'b0;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              bcnt_d = bcnt_q + 4'd1;
              oe_d   = ~sh_q[BYTE_W-2];
            end
          end
        end
        PH_MACK: begin
          if (scl_fall) ph_d = PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      kind_q <= BY_ADDR;
      bcnt_q <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
    end
  end

  assign wr_en   = byte_done && (kind_q == BY_DATA) && !start_det && !stop_det;
  assign wr_sub  = ptr_q;
  assign wr_data = sh_q;
  assign rd_sub  = ptr_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/flash_regbank.sv
module flash_regbank
  import flash_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_sub,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_sub,
  input  logic [FLT_W-1:0]  fault_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] out_reg,
  output logic [CFG_W-1:0]  cfg_reg,
  output logic              stb_reg,
  output logic [FLT_W-1:0]  flt_reg,
  output logic              fault_clr
);
  logic [BYTE_W-1:0] out_q, out_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              stb_q, stb_d;
  logic [FLT_W-1:0]  flt_q, flt_d;
  logic              clr_q, clr_d;

  always_comb begin
    out_d = out_q;
    cfg_d = cfg_q;
    stb_d = stb_q;
    flt_d = flt_q;
    clr_d = 1'b0;
    if (clr_all) begin
      out_d = '0;
      cfg_d = '0;
      stb_d = 1'b0;
      flt_d = '0;
    end else begin
      if (wr_en) begin
        case (wr_sub)
          SUB_OUT: begin
            out_d = wr_data;
            if (wr_data == '0) begin
              flt_d = '0;
              clr_d = 1'b1;
            end
          end
          SUB_CFG: cfg_d = wr_data[CFG_W-1:0];
          SUB_STB: stb_d = wr_data[0];
          default: ;
        endcase
      end
      // a live fault wins over a clear in the same cycle
      flt_d = flt_d | fault_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      cfg_q <= '0;
      stb_q <= 1'b0;
      flt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      out_q <= out_d;
      cfg_q <= cfg_d;
      stb_q <= stb_d;
      flt_q <= flt_d;
      clr_q <= clr_d;
    end
  end

  always_comb begin
    case (rd_sub)
      SUB_OUT: rd_data = out_q;
      SUB_CFG: rd_data = BYTE_W'(cfg_q);
      SUB_STB: rd_data = BYTE_W'(stb_q);
      SUB_FLT: rd_data = BYTE_W'(flt_q);
      default: rd_data = '0;
    endcase
  end

  assign out_reg   = out_q;
  assign cfg_reg   = cfg_q;
  assign stb_reg   = stb_q;
  assign flt_reg   = flt_q;
  assign fault_clr = clr_q;
endmodule

// File: rtl/flash_i2c_regfile.sv
module flash_i2c_regfile
  import flash_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h60,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              uv_flag,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [FLT_W-1:0]  fault_in,
  output logic [HP_W-1:0]   hp_level,
  output logic [IND_W-1:0]  ind_level,
  output logic              timed_mode,
  output logic [TSEL_W-1:0] flash_time,
  output logic              soft_strobe,
  output logic              fault_any,
  output logic              fault_clr
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_sub, wr_data, rd_sub, rd_data;
  logic [BYTE_W-1:0] out_reg;
  logic [CFG_W-1:0]  cfg_reg;
  logic [FLT_W-1:0]  flt_reg;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_f    (sda_f),
    .rd_data  (rd_data),
    .rd_sub   (rd_sub),
    .wr_en    (wr_en),
    .wr_sub   (wr_sub),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  flash_regbank u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (~chip_en | uv_flag),
    .wr_en    (wr_en),
    .wr_sub   (wr_sub),
    .wr_data  (wr_data),
    .rd_sub   (rd_sub),
    .fault_in (fault_in),
    .rd_data  (rd_data),
    .out_reg  (out_reg),
    .cfg_reg  (cfg_reg),
    .stb_reg  (soft_strobe),
    .flt_reg  (flt_reg),
    .fault_clr(fault_clr)
  );

  assign hp_level   = out_reg[BYTE_W-1:IND_W];
  assign ind_level  = out_reg[IND_W-1:0];
  assign timed_mode = cfg_reg[CFG_W-1];
  assign flash_time = cfg_reg[TSEL_W-1:0];
  assign fault_any  = |flt_reg;
endmodule

// File: rtl/flash_i2c_regfile_chk.sv
module flash_i2c_regfile_chk
  import flash_i2c_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              uv_flag,
  input logic [FLT_W-1:0]  fault_in,
  input logic [HP_W-1:0]   hp_level,
  input logic [IND_W-1:0]  ind_level,
  input logic              timed_mode,
  input logic [TSEL_W-1:0] flash_time,
  input logic              soft_strobe,
  input logic              fault_any,
  input logic              fault_clr
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en || uv_flag) |=> (hp_level == '0 && ind_level == '0 && !timed_mode &&
      flash_time == '0 && !soft_strobe && !fault_any && !fault_clr)); // R4

  AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !uv_flag && fault_in != '0) |=> fault_any); // R7

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && chip_en && !uv_flag) |=> (fault_any || fault_clr)); // R7

  AST_CLR_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |-> (hp_level == '0 && ind_level == '0)); // R6

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> !fault_clr); // R6
endmodule

bind flash_i2c_regfile flash_i2c_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_en    (chip_en),
  .uv_flag    (uv_flag),
  .fault_in   (fault_in),
  .hp_level   (hp_level),
  .ind_level  (ind_level),
  .timed_mode (timed_mode),
  .flash_time (flash_time),
  .soft_strobe(soft_strobe),
  .fault_any  (fault_any),
  .fault_clr  (fault_clr)
);

// File: tb/flash_i2c_regfile_bench.sv
`timescale 1ns/1ps
module flash_i2c_regfile_bench;
  localparam int H = 25;  // half SCL period in system clocks
  localparam int NVEC = 7;
  // {subaddress, write data, expected read-back}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00A5A5, 24'h01FF1F, 24'h020301, 24'h010A0A,
    24'h057700, 24'h03FF00, 24'h003838
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b1;
  logic uv_flag = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic [3:0] fault_in = 4'h0;
  logic sda_oe;
  logic sda_line;
  logic [4:0] hp_level;
  logic [2:0] ind_level;
  logic timed_mode;
  logic [3:0] flash_time;
  logic soft_strobe, fault_any, fault_clr;
  int checks = 0;
  int failures = 0;
  int clr_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_line = ~(m_sda_low | sda_oe);

  flash_i2c_regfile u_flash_i2c_regfile (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .uv_flag(uv_flag),
    .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe), .fault_in(fault_in),
    .hp_level(hp_level), .ind_level(ind_level), .timed_mode(timed_mode),
    .flash_time(flash_time), .soft_strobe(soft_strobe),
    .fault_any(fault_any), .fault_clr(fault_clr)
  );

  always @(negedge clk) if (fault_clr) clr_cnt <= clr_cnt + 1;

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wc(H);
    m_scl = 1'b1; wc(H);
    m_sda_low = 1'b1; wc(H);
    m_scl = 1'b0; wc(H);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wc(H);
    m_scl = 1'b1; wc(H);
    m_sda_low = 1'b0; wc(H);
  endtask

  task automatic put_byte(input logic [7:0] b, input int glitch_bit, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i];
      if (i == glitch_bit) begin
        wc(H / 2); m_scl = 1'b1; wc(2); m_scl = 1'b0; wc(H - H / 2 - 2);
      end else begin
        wc(H);
      end
      m_scl = 1'b1; wc(H);
      m_scl = 1'b0;
    end
    m_sda_low = 1'b0; wc(H);
    m_scl = 1'b1; wc(H / 2);
    acked = ~sda_line;
    wc(H - H / 2);
    m_scl = 1'b0;
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wc(H);
      m_scl = 1'b1; wc(H / 2);
      b[i] = sda_line;
      wc(H - H / 2);
      m_scl = 1'b0;
    end
    m_sda_low = ~nack; wc(H);
    m_scl = 1'b1; wc(H);
    m_scl = 1'b0;
    m_sda_low = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] sub, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start();
    put_byte({a, 1'b0}, -1, acks[2]);
    put_byte(sub, -1, acks[1]);
    put_byte(d, -1, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] sub, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    put_byte(8'hC0, -1, acks[2]);
    put_byte(sub, -1, acks[1]);
    bus_start();
    put_byte(8'hC1, -1, acks[0]);
    get_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic pulse_fault(input logic [3:0] f);
    fault_in = f; wc(1); fault_in = 4'h0; wc(2);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog act=timeout exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    logic a0;
    wc(5);
    rst_n = 1'b1;
    wc(5);
    // R4 reset state
    chk("R4 reset fields", {hp_level, ind_level, timed_mode, flash_time, soft_strobe, fault_any, fault_clr}, 0);
    chk("R4 reset sda_oe", sda_oe, 0);
    do_read(8'h00, rd, acks);
    chk("R4 reset reg0 read", rd, 8'h00);

    // table: write then read back (R2 R3 R5 R8)
    for (int v = 0; v < NVEC; v++) begin
      do_write(7'h60, VEC[v][23:16], VEC[v][15:8], acks);
      chk("R1 R8 write acks", acks, 3'b111);
      do_read(VEC[v][23:16], rd, acks);
      chk("R5 read acks", acks, 3'b111);
      chk("R2 R3 R5 R8 readback", rd, VEC[v][7:0]);
    end
    chk("R2 hp_level field", hp_level, 5'h07);
    chk("R2 ind_level field", ind_level, 3'h0);
    chk("R3 timed_mode field", timed_mode, 1'b0);
    chk("R3 flash_time field", flash_time, 4'hA);
    chk("R3 soft_strobe field", soft_strobe, 1'b1);

    // R1 foreign address
    do_write(7'h61, 8'h01, 8'h00, acks);
    chk("R1 foreign address ack", acks[2], 1'b0);
    do_read(8'h01, rd, acks);
    chk("R1 foreign write ignored", rd, 8'h0A);

    // R10 glitch on SCL during data byte
    bus_start();
    put_byte(8'hC0, -1, a0);
    put_byte(8'h01, -1, a0);
    put_byte(8'h15, 3, a0);
    bus_stop();
    do_read(8'h01, rd, acks);
    chk("R10 glitch filtered readback", rd, 8'h15);
    chk("R10 timed_mode", timed_mode, 1'b1);
    chk("R10 flash_time", flash_time, 4'h5);

    // R9 extra data byte
    bus_start();
    put_byte(8'hC0, -1, a0);
    put_byte(8'h02, -1, a0);
    put_byte(8'h00, -1, a0);
    chk("R9 first data ack", a0, 1'b1);
    put_byte(8'h01, -1, a0);
    chk("R9 extra byte nack", a0, 1'b0);
    bus_stop();
    chk("R9 extra byte not stored", soft_strobe, 1'b0);

    // R5 R7 faults
    pulse_fault(4'b0101);
    chk("R7 fault_any set", fault_any, 1'b1);
    do_read(8'h03, rd, acks);
    chk("R5 fault read", rd, 8'h05);
    pulse_fault(4'b1010);
    do_read(8'h03, rd, acks);
    chk("R7 fault sticky", rd, 8'h0F);

    // R6 clear behaviour
    do_write(7'h60, 8'h00, 8'h11, acks);
    do_read(8'h03, rd, acks);
    chk("R6 nonzero keeps faults", rd, 8'h0F);
    chk("R6 no clear pulse", clr_cnt, 0);
    do_write(7'h60, 8'h00, 8'h00, acks);
    chk("R6 one clear pulse", clr_cnt, 1);
    chk("R6 fault_any cleared", fault_any, 1'b0);
    do_read(8'h03, rd, acks);
    chk("R6 fault reg cleared", rd, 8'h00);

    // R4 chip_en low
    do_write(7'h60, 8'h00, 8'hFF, acks);
    do_write(7'h60, 8'h01, 8'h1F, acks);
    do_write(7'h60, 8'h02, 8'h01, acks);
    pulse_fault(4'b1000);
    chk("R4 setup fields", {hp_level, ind_level, timed_mode, flash_time, soft_strobe, fault_any}, 15'h7FFF);
    chip_en = 1'b0; wc(1); chip_en = 1'b1; wc(2);
    chk("R4 chip_en clears", {hp_level, ind_level, timed_mode, flash_time, soft_strobe, fault_any}, 0);
    do_read(8'h01, rd, acks);
    chk("R4 cfg read after disable", rd, 8'h00);

    // R4 undervoltage
    do_write(7'h60, 8'h00, 8'h81, acks);
    pulse_fault(4'b0010);
    uv_flag = 1'b1; wc(1); uv_flag = 1'b0; wc(2);
    chk("R4 uv_flag clears", {hp_level, ind_level, fault_any}, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule